// File: doc/BRIEF.md
# Custom Instruction Datapath Unit

This unit is a tightly coupled execution lane that sits beside a processor's integer ALU. The host pipeline has already decoded the instruction, read the register file and resolved hazards. It presents the unit with an instruction class, an accumulate bit, a dual-register bit, the instruction's immediate field, up to two source register values, the current value of the destination (or destination pair) and the current NZCV flags. The unit returns the result words, a write enable for each word and an optional flag update.

The immediate field does two jobs. Its low bits choose the operation and its upper bits form a small constant. That constant stands in for any source register the class does not supply. Population count, a flag-setting XOR, rotate and a 64-bit add all finish in one cycle. A 32x32 multiply-accumulate takes three cycles and is pipelined, so a new one can start every cycle. In 64-bit operation the low word belongs to the even register of the pair and the high word to the odd register.

Top module: `cx_dpu`

## Requirements
- R1: The immediate is 9 bits wide. Bits [2:0] select the operation, and bits [8:3] form a constant that is zero-extended to 32 bits.
- R2: The class input picks the operands. Class 0 uses the constant as both operands. Class 1 uses src_a as the first operand and the constant as the second. Classes 2 and 3 use src_a and src_b.
- R3: With acc set, the current destination is added to the operation's result. For a dual 64-bit operation this is {dst_hi, dst_lo}; otherwise it is dst_lo.
- R4: Operation 0 writes the number of set bits in the first operand to res_lo.
- R5: Operation 1 writes the XOR of the two operands. It is the only operation that raises flag_we. flags_out is {N,Z,C,V}, with N = res_lo[31] and Z = (res_lo == 0), while C and V are copied from flags_in.
- R6: Operation 2 rotates the first operand left by the second operand's bits [4:0].
- R7: Operation 4 forms the 64-bit sum of the zero-extended operands. When dual is set, the low word goes out on res_lo with wr_lo and the high word on res_hi with wr_hi. Otherwise, and for every other single-cycle operation, wr_hi is low and res_hi is zero.
- R8: Operation 3 multiplies the operands into a 64-bit product. Its result is valid exactly three cycles after issue, and one may be issued every cycle. Dual selects a 64-bit result; otherwise only the low word is written.
- R9: A single-cycle operation raises res_vld in the cycle after issue, and only for that cycle.
- R10: Operations 5, 6 and 7 raise res_vld with zero results and with wr_lo, wr_hi and flag_we all low.
- R11: If a multiply result and a single-cycle result fall due in the same cycle, the multiply result is returned and the single-cycle result is dropped.
- R12: While reset is asserted, res_vld, wr_lo, wr_hi and flag_we are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_vld | input | 1 | A pre-decoded instruction is issued this cycle |
| issue_cls | input | 2 | Operand class (number of register sources) |
| issue_acc | input | 1 | Accumulator variant |
| issue_dual | input | 1 | 64-bit even/odd register pair operation |
| issue_imm | input | 9 | Immediate: operation selector and constant |
| src_a | input | 32 | First source register value |
| src_b | input | 32 | Second source register value |
| dst_lo | input | 32 | Current destination (even register) value |
| dst_hi | input | 32 | Current odd register value of a destination pair |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| res_vld | output | 1 | Result valid |
| res_lo | output | 32 | Result word for the destination / even register |
| res_hi | output | 32 | Result word for the odd register |
| wr_lo | output | 1 | Write enable for res_lo |
| wr_hi | output | 1 | Write enable for res_hi |
| flag_we | output | 1 | Flag write enable |
| flags_out | output | 4 | New flags {N,Z,C,V} |

## Verification
Inputs are driven on the falling edge. A single-cycle operation is therefore captured at the next rising edge, and its result is sampled one falling edge later. At the falling edge after that, the bench confirms that res_vld has dropped again. A multiply is sampled at the third falling edge after issue, and the bench checks that res_vld stays low at the first and second. Back-to-back multiplies are expected on three consecutive falling edges. For the collision case, a single-cycle operation is issued two cycles after a multiply, and the bench expects the product in the shared cycle and an idle output in the cycle after it.

// File: rtl/cx_dpu_pkg.sv
package cx_dpu_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_POPC = 3'd0,
    OP_XORF = 3'd1,
    OP_ROTL = 3'd2,
    OP_MAC  = 3'd3,
    OP_ADDW = 3'd4
  } cx_op_e;

  typedef struct packed {
    logic vld;
    logic wlo;
    logic whi;
    logic fwe;
  } cx_wr_t;
endpackage

// File: rtl/cx_operand.sv
module cx_operand
  import cx_dpu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 9
) (
  input  logic [1:0]       cls,
  input  logic [IMM_W-1:0] imm,
  input  logic [XLEN-1:0]  src_a,
  input  logic [XLEN-1:0]  src_b,
  output cx_op_e           op,
  output logic [XLEN-1:0]  opa,
  output logic [XLEN-1:0]  opb
);
  localparam int CONST_W = IMM_W - OP_W;

  logic [XLEN-1:0] cval;

  always_comb begin
    op   = cx_op_e'(imm[OP_W-1:0]);
    cval = {{(XLEN-CONST_W){1'b0}}, imm[IMM_W-1:OP_W]};
    opa  = (cls == 2'b00) ? cval : src_a;
    opb  = cls[1] ? src_b : cval;
  end
endmodule

// File: rtl/cx_alu1.sv
module cx_alu1
  import cx_dpu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  cx_op_e          op,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic            acc,
  input  logic            dual,
  input  logic [XLEN-1:0] dst_lo,
  input  logic [XLEN-1:0] dst_hi,
  input  logic [3:0]      flags_in,
  output logic [XLEN-1:0] res_lo,
  output logic [XLEN-1:0] res_hi,
  output cx_wr_t          wr,
  output logic [3:0]      flags
);
  localparam int SH_W  = $clog2(XLEN);
  localparam int CNT_W = SH_W + 1;

  logic [CNT_W-1:0]  cnt;
  logic [2*XLEN-1:0] rot2;
  logic [2*XLEN-1:0] wide;
  logic [2*XLEN-1:0] acc64;
  logic [XLEN-1:0]   core;
  logic [XLEN-1:0]   acc32;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < XLEN; i++) begin
      cnt = cnt + CNT_W'(opa[i]);
    end
  end

  always_comb begin
    rot2  = {opa, opa} << opb[SH_W-1:0];
    acc32 = acc ? dst_lo : '0;
    acc64 = !acc ? '0 : (dual ? {dst_hi, dst_lo} : {{XLEN{1'b0}}, dst_lo});
    wide  = {{XLEN{1'b0}}, opa} + {{XLEN{1'b0}}, opb} + acc64;
    core   = '0;
    res_lo = '0;
    res_hi = '0;
    wr     = '{vld: 1'b1, wlo: 1'b0, whi: 1'b0, fwe: 1'b0};
    unique case (op)
      OP_POPC: begin
        core   = {{(XLEN-CNT_W){1'b0}}, cnt};
        res_lo = core + acc32;
        wr.wlo = 1'b1;
      end
      OP_XORF: begin
        core   = opa ^ opb;
        res_lo = core + acc32;
        wr.wlo = 1'b1;
        wr.fwe = 1'b1;
      end
      OP_ROTL: begin
        core   = rot2[2*XLEN-1:XLEN];
        res_lo = core + acc32;
        wr.wlo = 1'b1;
      end
      OP_ADDW: begin
        res_lo = wide[XLEN-1:0];
        res_hi = dual ? wide[2*XLEN-1:XLEN] : '0;
        wr.wlo = 1'b1;
        wr.whi = dual;
      end
      default: begin
        res_lo = '0;
      end
    endcase
    flags = {res_lo[XLEN-1], (res_lo == '0), flags_in[1:0]};
  end
endmodule

// File: rtl/cx_mac.sv
module cx_mac #(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [XLEN-1:0]   opa,
  input  logic [XLEN-1:0]   opb,
  input  logic [2*XLEN-1:0] acc_val,
  input  logic              dual_in,
  output logic              out_vld,
  output logic [2*XLEN-1:0] out_val,
  output logic              out_dual
);
  logic              v1_q, v1_d;
  logic [XLEN-1:0]   a1_q, a1_d, b1_q, b1_d;
  logic [2*XLEN-1:0] c1_q, c1_d;
  logic              d1_q, d1_d;
  logic              v2_q, v2_d;
  logic [2*XLEN-1:0] p2_q, p2_d;
  logic              d2_q, d2_d;

  always_comb begin
    v1_d = in_vld;
    a1_d = opa;
    b1_d = opb;
    c1_d = acc_val;
    d1_d = dual_in;
    v2_d = v1_q;
    p2_d = ({{XLEN{1'b0}}, a1_q} * {{XLEN{1'b0}}, b1_q}) + c1_q;
    d2_d = d1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
      a1_q <= '0;
      b1_q <= '0;
      c1_q <= '0;
      d1_q <= 1'b0;
      p2_q <= '0;
      d2_q <= 1'b0;
    end else begin
      v1_q <= v1_d;
      v2_q <= v2_d;
      if (in_vld) begin
        a1_q <= a1_d;
        b1_q <= b1_d;
        c1_q <= c1_d;
        d1_q <= d1_d;
      end
      if (v1_q) begin
        p2_q <= p2_d;
        d2_q <= d2_d;
      end
    end
  end

  assign out_vld  = v2_q;
  assign out_val  = p2_q;
  assign out_dual = d2_q;
endmodule

// File: rtl/cx_dpu.sv
module cx_dpu
  import cx_dpu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_vld,
  input  logic [1:0]       issue_cls,
  input  logic             issue_acc,
  input  logic             issue_dual,
  input  logic [IMM_W-1:0] issue_imm,
  input  logic [XLEN-1:0]  src_a,
  input  logic [XLEN-1:0]  src_b,
  input  logic [XLEN-1:0]  dst_lo,
  input  logic [XLEN-1:0]  dst_hi,
  input  logic [3:0]       flags_in,
  output logic             res_vld,
  output logic [XLEN-1:0]  res_lo,
  output logic [XLEN-1:0]  res_hi,
  output logic             wr_lo,
  output logic             wr_hi,
  output logic             flag_we,
  output logic [3:0]       flags_out
);
  cx_op_e            op;
  logic [XLEN-1:0]   opa, opb;
  logic [XLEN-1:0]   alu_lo, alu_hi;
  cx_wr_t            alu_wr;
  logic [3:0]        alu_flags;
  logic              sc_vld, mac_in;
  logic [2*XLEN-1:0] mac_acc;
  logic              mac_vld, mac_dual;
  logic [2*XLEN-1:0] mac_val;

  cx_wr_t            wr_q, wr_d;
  logic [XLEN-1:0]   lo_q, lo_d, hi_q, hi_d;
  logic [3:0]        fl_q, fl_d;
  logic              load_en;

  cx_operand #(.XLEN(XLEN), .IMM_W(IMM_W)) u_opnd (
    .cls   (issue_cls),
    .imm   (issue_imm),
    .src_a (src_a),
    .src_b (src_b),
    .op    (op),
    .opa   (opa),
    .opb   (opb)
  );

  cx_alu1 #(.XLEN(XLEN)) u_alu1 (
    .op       (op),
    .opa      (opa),
    .opb      (opb),
    .acc      (issue_acc),
    .dual     (issue_dual),
    .dst_lo   (dst_lo),
    .dst_hi   (dst_hi),
    .flags_in (flags_in),
    .res_lo   (alu_lo),
    .res_hi   (alu_hi),
    .wr       (alu_wr),
    .flags    (alu_flags)
  );

  always_comb begin
    mac_in  = issue_vld && (op == OP_MAC);
    sc_vld  = issue_vld && (op != OP_MAC);
    mac_acc = !issue_acc ? '0 :
              (issue_dual ? {dst_hi, dst_lo} : {{XLEN{1'b0}}, dst_lo});
  end

  cx_mac #(.XLEN(XLEN)) u_mac (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (mac_in),
    .opa      (opa),
    .opb      (opb),
    .acc_val  (mac_acc),
    .dual_in  (issue_dual),
    .out_vld  (mac_vld),
    .out_val  (mac_val),
    .out_dual (mac_dual)
  );

  // Result stage: a completing multiply takes precedence over a single-cycle op.
  always_comb begin
    load_en = mac_vld || sc_vld;
    if (mac_vld) begin
      wr_d = '{vld: 1'b1, wlo: 1'b1, whi: mac_dual, fwe: 1'b0};
      lo_d = mac_val[XLEN-1:0];
      hi_d = mac_dual ? mac_val[2*XLEN-1:XLEN] : '0;
      fl_d = flags_in;
    end else if (sc_vld) begin
      wr_d = alu_wr;
      lo_d = alu_lo;
      hi_d = alu_hi;
      fl_d = alu_flags;
    end else begin
      wr_d = '0;
      lo_d = lo_q;
      hi_d = hi_q;
      fl_d = fl_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      lo_q <= '0;
      hi_q <= '0;
      fl_q <= '0;
    end else begin
      wr_q <= wr_d;
      if (load_en) begin
        lo_q <= lo_d;
        hi_q <= hi_d;
        fl_q <= fl_d;
      end
    end
  end

  assign res_vld   = wr_q.vld;
  assign wr_lo     = wr_q.wlo;
  assign wr_hi     = wr_q.whi;
  assign flag_we   = wr_q.fwe;
  assign res_lo    = lo_q;
  assign res_hi    = hi_q;
  assign flags_out = fl_q;
endmodule

// File: rtl/cx_dpu_chk.sv
module cx_dpu_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            issue_vld,
  input logic [2:0]      issue_op,
  input logic [3:0]      flags_in,
  input logic            res_vld,
  input logic [XLEN-1:0] res_lo,
  input logic [XLEN-1:0] res_hi,
  input logic            wr_lo,
  input logic            wr_hi,
  input logic            flag_we,
  input logic [3:0]      flags_out
);
  AST_SC_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld && (issue_op != 3'd3) |=> res_vld);  // R9

  AST_MAC_THREE_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld && (issue_op == 3'd3) |-> ##3 res_vld);  // R8

  AST_VLD_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> $past(issue_vld) || $past(issue_vld, 3));  // R9

  AST_HI_NEEDS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |-> wr_lo && res_vld);  // R7

  AST_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld && !wr_hi |-> res_hi == '0);  // R7

  AST_FLAG_NZ: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |-> (flags_out[3] == res_lo[XLEN-1]) && (flags_out[2] == (res_lo == '0)));  // R5

  AST_FLAG_CV_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |-> flags_out[1:0] == $past(flags_in[1:0]));  // R5

  AST_FLAG_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |-> wr_lo && res_vld);  // R5

  always_comb begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!res_vld && !wr_lo && !wr_hi && !flag_we);  // R12
    end
  end
endmodule

bind cx_dpu cx_dpu_chk #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .issue_vld (issue_vld),
  .issue_op  (issue_imm[2:0]),
  .flags_in  (flags_in),
  .res_vld   (res_vld),
  .res_lo    (res_lo),
  .res_hi    (res_hi),
  .wr_lo     (wr_lo),
  .wr_hi     (wr_hi),
  .flag_we   (flag_we),
  .flags_out (flags_out)
);

// File: tb/cx_dpu_tb.sv
module cx_dpu_tb;
  logic        clk;
  logic        rst_n;
  logic        issue_vld;
  logic [1:0]  issue_cls;
  logic        issue_acc;
  logic        issue_dual;
  logic [8:0]  issue_imm;
  logic [31:0] src_a, src_b, dst_lo, dst_hi;
  logic [3:0]  flags_in;
  logic        res_vld;
  logic [31:0] res_lo, res_hi;
  logic        wr_lo, wr_hi, flag_we;
  logic [3:0]  flags_out;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;

  cx_dpu u_dut (
    .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld), .issue_cls(issue_cls),
    .issue_acc(issue_acc), .issue_dual(issue_dual), .issue_imm(issue_imm),
    .src_a(src_a), .src_b(src_b), .dst_lo(dst_lo), .dst_hi(dst_hi),
    .flags_in(flags_in), .res_vld(res_vld), .res_lo(res_lo), .res_hi(res_hi),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .flag_we(flag_we), .flags_out(flags_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual cycles=%0d expected < 20000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  typedef struct packed {
    logic [1:0]  cls;
    logic        acc;
    logic        dual;
    logic [8:0]  imm;
    logic [31:0] a, b, dlo, dhi;
    logic [3:0]  fin;
    logic [31:0] elo, ehi;
    logic        ewlo, ewhi, efwe;
    logic [3:0]  eflg;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    // R4 popcount, class 1
    '{2'd1, 1'b0, 1'b0, 9'h000, 32'hFFFF_FFFF, 32'h0, 32'h0, 32'h0, 4'h0, 32'd32, 32'h0, 1'b1, 1'b0, 1'b0, 4'h0},
    // R3 accumulating popcount
    '{2'd1, 1'b1, 1'b0, 9'h000, 32'h8000_0001, 32'h0, 32'd10, 32'h0, 4'h0, 32'd12, 32'h0, 1'b1, 1'b0, 1'b0, 4'h0},
    // R1 R2 class 0 popcount of constant 0x3F
    '{2'd0, 1'b0, 1'b0, 9'h1F8, 32'h0, 32'h0, 32'h0, 32'h0, 4'h0, 32'd6, 32'h0, 1'b1, 1'b0, 1'b0, 4'h0},
    // R5 xor, N set, C V passed
    '{2'd2, 1'b0, 1'b0, 9'h001, 32'hF0F0_0000, 32'h0F0F_0000, 32'h0, 32'h0, 4'b0011, 32'hFFFF_0000, 32'h0, 1'b1, 1'b0, 1'b1, 4'b1011},
    // R5 xor, Z set, N cleared
    '{2'd2, 1'b0, 1'b0, 9'h001, 32'h1234, 32'h1234, 32'h0, 32'h0, 4'b1000, 32'h0, 32'h0, 1'b1, 1'b0, 1'b1, 4'b0100},
    // R3 R1 accumulating xor with constant 2
    '{2'd1, 1'b1, 1'b0, 9'h011, 32'h5, 32'h0, 32'h1, 32'h0, 4'b0010, 32'h8, 32'h0, 1'b1, 1'b0, 1'b1, 4'b0010},
    // R6 rotate by register
    '{2'd2, 1'b0, 1'b0, 9'h002, 32'h8000_0001, 32'h4, 32'h0, 32'h0, 4'h0, 32'h18, 32'h0, 1'b1, 1'b0, 1'b0, 4'h0},
    // R6 rotate by constant 31
    '{2'd1, 1'b0, 1'b0, 9'h0FA, 32'h1, 32'h0, 32'h0, 32'h0, 4'h0, 32'h8000_0000, 32'h0, 1'b1, 1'b0, 1'b0, 4'h0},
    // R7 64-bit add into pair
    '{2'd2, 1'b0, 1'b1, 9'h004, 32'hFFFF_FFFF, 32'h1, 32'h0, 32'h0, 4'h0, 32'h0, 32'h1, 1'b1, 1'b1, 1'b0, 4'h0},
    // R7 R3 64-bit accumulating add
    '{2'd2, 1'b1, 1'b1, 9'h004, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h2, 32'h3, 4'h0, 32'h0, 32'h5, 1'b1, 1'b1, 1'b0, 4'h0},
    // R7 add without dual: no high write
    '{2'd2, 1'b0, 1'b0, 9'h004, 32'hFFFF_FFFF, 32'h2, 32'h0, 32'h7, 4'h0, 32'h1, 32'h0, 1'b1, 1'b0, 1'b0, 4'h0},
    // R7 dual on 32-bit op: no high write
    '{2'd1, 1'b0, 1'b1, 9'h000, 32'hF, 32'h0, 32'h0, 32'h9, 4'h0, 32'd4, 32'h0, 1'b1, 1'b0, 1'b0, 4'h0},
    // R10 reserved selector 5
    '{2'd2, 1'b0, 1'b0, 9'h005, 32'h1, 32'h1, 32'h0, 32'h0, 4'hF, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 4'h0},
    // R10 reserved selector 7
    '{2'd2, 1'b1, 1'b1, 9'h007, 32'h1, 32'h1, 32'h3, 32'h3, 4'hF, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 4'h0},
    // R8 multiply 32-bit
    '{2'd2, 1'b0, 1'b0, 9'h003, 32'd7, 32'd6, 32'h0, 32'h0, 4'h0, 32'd42, 32'h0, 1'b1, 1'b0, 1'b0, 4'h0},
    // R8 multiply 64-bit
    '{2'd2, 1'b0, 1'b1, 9'h003, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h0, 4'h0, 32'h1, 32'hFFFF_FFFE, 1'b1, 1'b1, 1'b0, 4'h0},
    // R8 R3 multiply-accumulate 64-bit
    '{2'd2, 1'b1, 1'b1, 9'h003, 32'h1, 32'h1, 32'hFFFF_FFFF, 32'h0, 4'h0, 32'h0, 32'h1, 1'b1, 1'b1, 1'b0, 4'h0},
    // R8 R2 multiply-accumulate with constant 5
    '{2'd1, 1'b1, 1'b0, 9'h02B, 32'h3, 32'h0, 32'h64, 32'h0, 4'h0, 32'h73, 32'h0, 1'b1, 1'b0, 1'b0, 4'h0},
    // R2 R5 class 0: constant xor constant
    '{2'd0, 1'b0, 1'b0, 9'h049, 32'hAAAA, 32'h5555, 32'h0, 32'h0, 4'b0001, 32'h0, 32'h0, 1'b1, 1'b0, 1'b1, 4'b0101}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    issue_vld = 1'b0; issue_cls = '0; issue_acc = 1'b0; issue_dual = 1'b0;
    issue_imm = '0; src_a = '0; src_b = '0; dst_lo = '0; dst_hi = '0; flags_in = '0;
  endtask

  task automatic drive(input vec_t v);
    issue_vld = 1'b1; issue_cls = v.cls; issue_acc = v.acc; issue_dual = v.dual;
    issue_imm = v.imm; src_a = v.a; src_b = v.b; dst_lo = v.dlo; dst_hi = v.dhi;
    flags_in = v.fin;
  endtask

  task automatic compare(input vec_t v, input string req);
    logic ok;
    ok = res_vld && (res_lo == v.elo) && (res_hi == v.ehi) && (wr_lo == v.ewlo) &&
         (wr_hi == v.ewhi) && (flag_we == v.efwe) && (!v.efwe || flags_out == v.eflg);
    chk(ok, req,
        {res_vld, wr_lo, wr_hi, flag_we, flags_out, 24'h0, res_hi[3:0], res_lo},
        {1'b1, v.ewlo, v.ewhi, v.efwe, v.eflg, 24'h0, v.ehi[3:0], v.elo});
  endtask

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R12: quiet outputs while in reset
    chk(!res_vld && !wr_lo && !wr_hi && !flag_we, "R12 reset",
        {60'h0, res_vld, wr_lo, wr_hi, flag_we}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!res_vld, "R12 after release", {63'h0, res_vld}, 64'h0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      bit is_mac;
      is_mac = (VEC[i].imm[2:0] == 3'd3);
      drive(VEC[i]);
      @(negedge clk);
      idle_inputs();
      if (is_mac) begin
        chk(!res_vld, "R8 not early (1)", {63'h0, res_vld}, 64'h0);
        @(negedge clk);
        chk(!res_vld, "R8 not early (2)", {63'h0, res_vld}, 64'h0);
        @(negedge clk);
        compare(VEC[i], "R8 multiply result");
      end else begin
        compare(VEC[i], $sformatf("vector %0d", i));
      end
      @(negedge clk);
      chk(!res_vld, "R9 single pulse", {63'h0, res_vld}, 64'h0);
    end

    // R8: back-to-back multiplies, one result per cycle
    for (int k = 0; k < 3; k++) begin
      idle_inputs();
      issue_vld = 1'b1; issue_cls = 2'd2; issue_imm = 9'h003;
      src_a = 32'(2 * k + 2); src_b = 32'(2 * k + 3);
      @(negedge clk);
    end
    idle_inputs();
    // issues at negedges n0,n1,n2 -> results at n3,n4,n5; now at n3
    chk(res_vld && res_lo == 32'd6, "R8 pipelined 1", {32'h0, res_lo}, 64'd6);
    @(negedge clk);
    chk(res_vld && res_lo == 32'd20, "R8 pipelined 2", {32'h0, res_lo}, 64'd20);
    @(negedge clk);
    chk(res_vld && res_lo == 32'd42, "R8 pipelined 3", {32'h0, res_lo}, 64'd42);
    @(negedge clk);
    chk(!res_vld, "R8 pipeline drained", {63'h0, res_vld}, 64'h0);

    // R11: multiply and single-cycle result due together
    issue_vld = 1'b1; issue_cls = 2'd2; issue_imm = 9'h003; src_a = 32'd2; src_b = 32'd3;
    @(negedge clk);
    idle_inputs();
    @(negedge clk);
    issue_vld = 1'b1; issue_cls = 2'd2; issue_imm = 9'h001; src_a = 32'h1; src_b = 32'h0;
    @(negedge clk);
    idle_inputs();
    chk(res_vld && res_lo == 32'd6 && !flag_we, "R11 multiply wins",
        {31'h0, flag_we, res_lo}, {32'h0, 32'd6});
    @(negedge clk);
    chk(!res_vld, "R11 single-cycle dropped", {63'h0, res_vld}, 64'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule